// File: doc/BRIEF.md
# Cascaded Synchronous Up-Counter

This block is a wide synchronous up-counter assembled from identical 4-bit counter slices, three by default, which gives a 12-bit count. A small control stage turns the shared active-low clear, the shared active-low load and the master count enable into a set of active-high strobes. Every slice receives these strobes. Each slice has two count enables. The first is the master enable, which is common to all slices. The second is a chain enable that comes from the carry of the slice below.

A slice's carry is gated by its own chain enable. A slice at 1111 therefore raises its carry only while every slice below it is also at 1111. This keeps a higher slice from counting on a stale carry after a lower slice has wrapped. All registers are clocked by one rising-edge clock. The block has no separate reset, so the clear input must be held low for at least one edge before the count is used.

Top module: `cascade_counter`

## Requirements
- R1: On a rising edge with clrN low, the count becomes 0, even when ldN is also low and masterEn is high.
- R2: On a rising edge with clrN high and ldN low, the count takes loadVal, and this takes priority over counting. Bits [3:0] of loadVal go to the lowest slice, and each next group of four bits goes to the next slice up.
- R3: On a rising edge with clrN high, ldN high and masterEn high, the full-width count increments by one, with the carry passing between slices.
- R4: On a rising edge with clrN high, ldN high and masterEn low, the count holds its value.
- R5: carryOut is 1 exactly when every bit of the count is 1, whatever the value of masterEn, and is 0 otherwise.
- R6: The count goes from 0x0EF to 0x0F0 and then to 0x0F1. A slice at 1111 whose lower slices are not all 1111 must not let the slice above it advance.
- R7: When counting from all ones, the count wraps to 0 and carryOut falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all slices |
| clrN | input | 1 | Active-low synchronous clear, shared by all slices |
| ldN | input | 1 | Active-low synchronous parallel load, shared by all slices |
| masterEn | input | 1 | Master count enable, driven to the first enable of every slice |
| loadVal | input | 4*SLICES | Parallel load value; the least significant nibble goes to the lowest slice |
| count | output | 4*SLICES | Full-width count value |
| carryOut | output | 1 | Carry of the highest slice, high in the all-ones state |

## Verification
A vector table tries the counter with the following patterns:
- clear together with load, to show that clear wins;
- load together with count, to show that load wins;
- enable held low, to show the count holds;
- a single-slice increment and an increment that crosses a slice boundary;
- the all-ones state with the enable off and on, which separates carry gating from master enable gating;
- the 0x0EF to 0x0F0 to 0x0F1 walk, which exposes a stale middle carry.

A long random run of clear, load and enable is then compared each cycle with a plain full-width counter that uses the same priority. This catches chaining faults that only appear at particular nibble values.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int SLICE_W = 4;

  // Resolved, active-high strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
(
  input  logic         clrN,
  input  logic         ldN,
  input  logic         masterEn,
  output ctrlStrobes_t strb
);
  // Priority: clear, then load, then count
  always_comb begin
    strb.clear   = ~clrN;
    strb.load    = clrN & ~ldN;
    strb.advance = clrN & ldN & masterEn;
  end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
(
  input  logic               clk,
  input  ctrlStrobes_t       strb,
  input  logic               enT,
  input  logic [SLICE_W-1:0] loadNib,
  output logic [SLICE_W-1:0] nib,
  output logic               carry
);
  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  always_ff @(posedge clk) begin
    if (strb.clear)                  nib <= '0;
    else if (strb.load)              nib <= loadNib;
    else if (strb.advance && enT)    nib <= nib + ONE;
  end

  // Carry is gated by this slice's own chain enable
  assign carry = (&nib) & enT;

  // R2: a load strobe puts the load nibble into the slice
  assert_load_nibble_R2: assert property (@(posedge clk) disable iff (strb.clear)
    strb.load |=> nib == $past(loadNib));

  // R3: both enables high means the slice increments
  assert_slice_inc_R3: assert property (@(posedge clk) disable iff (strb.clear)
    (!strb.load && strb.advance && enT) |=> nib == $past(nib) + ONE);

  // R4: without both enables, the slice holds its value
  assert_slice_hold_R4: assert property (@(posedge clk) disable iff (strb.clear)
    (!strb.load && !(strb.advance && enT)) |=> $stable(nib));
endmodule

// File: rtl/ctr_chain.sv
module ctr_chain
  import ctr_pkg::*;
#(
  parameter int SLICES = 3
) (
  input  logic                       clk,
  input  ctrlStrobes_t               strb,
  input  logic [SLICES*SLICE_W-1:0]  loadVal,
  output logic [SLICES*SLICE_W-1:0]  count,
  output logic                       carryOut
);
  localparam int COUNT_W = SLICES * SLICE_W;

  logic [SLICES:0]   chainT;
  logic [SLICES-1:0] sliceCarry;

  assign chainT[0] = 1'b1;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    ctr_slice u_slice (
      .clk     (clk),
      .strb    (strb),
      .enT     (chainT[i]),
      .loadNib (loadVal[i*SLICE_W +: SLICE_W]),
      .nib     (count[i*SLICE_W +: SLICE_W]),
      .carry   (sliceCarry[i])
    );
    assign chainT[i+1] = sliceCarry[i];
  end

  assign carryOut = chainT[SLICES];

  // R1: a clear strobe leaves the whole count at zero
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (strb.clear)
    $past(strb.clear) |-> count == '0);

  // R5: the final carry marks exactly the all-ones state
  assert_carry_allones_R5: assert property (@(posedge clk) disable iff (strb.clear)
    carryOut == (count == {COUNT_W{1'b1}}));

  // R6: upper slices do not move unless the lowest nibble is all ones
  if (SLICES > 1) begin : g_upper_chk
    assert_no_stale_carry_R6: assert property (@(posedge clk) disable iff (strb.clear)
      (!strb.load && !(&count[SLICE_W-1:0]))
        |=> count[COUNT_W-1:SLICE_W] == $past(count[COUNT_W-1:SLICE_W]));
  end

  // R7: counting from all ones wraps to zero
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (strb.clear)
    (!strb.load && strb.advance && count == {COUNT_W{1'b1}}) |=> count == '0);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import ctr_pkg::*;
#(
  parameter int SLICES = 3
) (
  input  logic                     clk,
  input  logic                     clrN,
  input  logic                     ldN,
  input  logic                     masterEn,
  input  logic [SLICES*4-1:0]      loadVal,
  output logic [SLICES*4-1:0]      count,
  output logic                     carryOut
);
  ctrlStrobes_t strb;

  ctr_ctrl u_ctrl (
    .clrN     (clrN),
    .ldN      (ldN),
    .masterEn (masterEn),
    .strb     (strb)
  );

  ctr_chain #(.SLICES(SLICES)) u_chain (
    .clk      (clk),
    .strb     (strb),
    .loadVal  (loadVal),
    .count    (count),
    .carryOut (carryOut)
  );
endmodule

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;
  localparam int CLK_PERIOD = 10;
  localparam int SLICES = 3;
  localparam int W = SLICES * 4;
  localparam int NVEC = 15;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic          clrN;
    logic          ldN;
    logic          en;
    logic [11:0]   ldv;
    logic [11:0]   expCnt;
    logic          expCarry;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 12'h123, 12'h000, 1'b0},  // R1 clear beats load
    '{1'b1, 1'b0, 1'b0, 12'h5A3, 12'h5A3, 1'b0},  // R2 load
    '{1'b1, 1'b1, 1'b1, 12'h000, 12'h5A4, 1'b0},  // R3 count
    '{1'b1, 1'b1, 1'b0, 12'h000, 12'h5A4, 1'b0},  // R4 hold
    '{1'b1, 1'b0, 1'b1, 12'h0FE, 12'h0FE, 1'b0},  // R2 load over count
    '{1'b1, 1'b1, 1'b1, 12'h000, 12'h0FF, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 12'h000, 12'h100, 1'b0},  // R3 cross two slices
    '{1'b1, 1'b0, 1'b0, 12'hFFF, 12'hFFF, 1'b1},  // R5 carry with enable off
    '{1'b1, 1'b1, 1'b0, 12'h000, 12'hFFF, 1'b1},  // R5
    '{1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0},  // R7 wrap
    '{1'b1, 1'b0, 1'b1, 12'h0EF, 12'h0EF, 1'b0},  // R2
    '{1'b1, 1'b1, 1'b1, 12'h000, 12'h0F0, 1'b0},  // R6
    '{1'b1, 1'b1, 1'b1, 12'h000, 12'h0F1, 1'b0},  // R6 no stale carry
    '{1'b1, 1'b0, 1'b1, 12'h0FF, 12'h0FF, 1'b0},  // R2
    '{1'b0, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0}   // R1
  };

  logic         clk = 1'b0;
  logic         clrN = 1'b0;
  logic         ldN = 1'b1;
  logic         masterEn = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic [W-1:0] count;
  logic         carryOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  cascade_counter #(.SLICES(SLICES)) u0 (
    .clk      (clk),
    .clrN     (clrN),
    .ldN      (ldN),
    .masterEn (masterEn),
    .loadVal  (loadVal),
    .count    (count),
    .carryOut (carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string rowTag(int idx);
    case (idx)
      0, 14:         return "R1";
      1, 4, 10, 13:  return "R2";
      2, 5, 6:       return "R3";
      3:             return "R4";
      7, 8:          return "R5";
      9:             return "R7";
      default:       return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] expCnt, logic expCarry);
    total++;
    if (count !== expCnt || carryOut !== expCarry) begin
      bad++;
      $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
               tag, count, carryOut, expCnt, expCarry);
    end
  endtask

  task automatic step(logic c, logic l, logic e, logic [W-1:0] v);
    @(negedge clk);
    clrN = c; ldN = l; masterEn = e; loadVal = v;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] model;

    // Reset state after clear (R1)
    @(posedge clk);
    #1;
    check("R1", '0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].clrN, VECS[i].ldN, VECS[i].en, VECS[i].ldv);
      check(rowTag(i), VECS[i].expCnt, VECS[i].expCarry);
    end

    // R6: a full lower-slice walk, with the upper slice checked each step
    step(1'b1, 1'b0, 1'b0, 12'h1E0);
    model = 12'h1E0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b1, 1'b1, '0);
      model = model + 1'b1;
      check("R6", model, 1'b0);
    end

    // R7: wrap from all ones, then continue counting
    step(1'b1, 1'b0, 1'b1, 12'hFFE);
    step(1'b1, 1'b1, 1'b1, '0);
    check("R5", 12'hFFF, 1'b1);
    step(1'b1, 1'b1, 1'b1, '0);
    check("R7", 12'h000, 1'b0);
    step(1'b1, 1'b1, 1'b1, '0);
    check("R7", 12'h001, 1'b0);

    // Random run against a plain wide counter (R1-style priority, R3, R4)
    model = count;
    for (int i = 0; i < 4000; i++) begin
      logic c, l, e;
      logic [W-1:0] v;
      c = ($urandom_range(0, 31) != 0);
      l = ($urandom_range(0, 7) != 0);
      e = ($urandom_range(0, 3) != 0);
      v = W'($urandom);
      if ($urandom_range(0, 15) == 0) v = {W{1'b1}} - W'($urandom_range(0, 2));
      step(c, l, e, v);
      if (!c)      model = '0;
      else if (!l) model = v;
      else if (e)  model = model + 1'b1;
      check(!c ? "R1" : (!l ? "R2" : (e ? "R3" : "R4")), model, &model);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule